// File: doc/BRIEF.md
# Character LCD Controller Host Register Interface

This block is the side of a character LCD controller that faces a microprocessor. The host drives a register-select line, a read/write line and a data byte, and then drops an enable strobe. The falling edge of the strobe commits the access. The block keeps an instruction register that the host can only write and a data register that the host can read and write. It also keeps a 7-bit address counter that points into one of two external RAMs: an 80-byte display RAM and a 64-byte character-generator RAM. A busy flag guards the accesses that need time to complete.

A data write is stored into the selected RAM at the counter address. A data read returns the data register, and the block then fetches the byte at the next address into the data register by itself. After every data access the counter moves one step in the programmed direction and wraps within the selected RAM. The host bus can be folded into two 4-bit transfers on the upper four data lines, with the high nibble first.

The RAM side is a plain synchronous port with no back-pressure. The RAM must accept a request on every cycle that `ram_en` is high. It must return read data exactly one cycle after a read request. The internal transfer pulse from the bus sampler to the decoder also has no ready signal, because the host strobe rate bounds it.

Top module: `lcd_host_regif`

## Requirements
- R1: When RS=0 and RW=0 at the fall of E, the byte is an instruction, decoded as follows. `1aaaaaaa` sets a display RAM address. `01aaaaaa` sets a character RAM address. `001dxxxx` is a mode set, where d=1 selects the 8-bit bus and d=0 selects the 4-bit bus. `000001ix` sets the direction, where i=1 selects increment and i=0 selects decrement. Any other code changes nothing except the busy flag.
- R2: When RS=0 and RW=1, the byte presented is the status byte: the busy flag on bit 7 and the address counter on bits 6..0. The instruction register is never presented to the host.
- R3: When RS=1 and RW=0, the byte is stored into the currently selected RAM at the counter address. The same byte is also kept in the data register.
- R4: When RS=1 and RW=1, the byte presented is the data register. After that read, the byte at the next address is loaded into the data register without further host action.
- R5: After each data write or data read, the address counter moves by exactly one. It moves up when the direction is increment and down when the direction is decrement.
- R6: The counter wraps within the selected RAM. For display RAM, 0x4F is followed by 0x00 when incrementing, and 0x00 is followed by 0x4F when decrementing. For character RAM, the wrap points are 0x3F and 0x00.
- R7: A set-address instruction loads the counter, selects the RAM, and prefetches the byte at the new address into the data register. A display address above 0x4F loads 0x00.
- R8: The busy flag is high for exactly BUSY_CYCLES clock cycles. It starts the cycle after the committed transfer of any instruction write or data write.
- R9: While busy is high, any access other than a status read has no effect at all: no RAM write, no counter step and no prefetch.
- R10: In 4-bit mode, only DB7..DB4 carry data, with the high nibble on the first strobe and the low nibble on the second. A read presents the high nibble and then the low nibble on `bus_dout[7:4]`, with `bus_dout[3:0]` = 0. The access takes effect on the second nibble.
- R11: After reset, the block uses the 8-bit bus, increment direction and display RAM, with the counter at 0. The busy flag is low, the data register is 0, and no RAM request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_e | input | 1 | Host enable strobe; the falling edge commits the access |
| bus_rs | input | 1 | Register select: 0 selects instruction/status, 1 selects data |
| bus_rw | input | 1 | 1 selects read, 0 selects write |
| bus_din | input | 8 | Host write data (DB7..DB4 only in 4-bit mode) |
| bus_dout | output | 8 | Host read data, chosen by bus_rs |
| busy | output | 1 | Busy flag |
| ram_en | output | 1 | RAM request |
| ram_we | output | 1 | RAM write (valid with ram_en) |
| ram_char | output | 1 | 1 selects character RAM, 0 selects display RAM |
| ram_addr | output | 7 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after a read request |

## Verification
The assertions assume that `bus_e` is synchronous to `clk` and that every strobe spends at least one cycle high and one cycle low. Two committed transfers are therefore never on adjacent cycles. They also assume that data reads are spaced wider than the four-cycle prefetch, and that the RAM honours the one-cycle read latency. The bench holds E high for one cycle and low for at least one cycle. During busy it issues strobes back-to-back on purpose, but otherwise it waits out the busy window and the prefetch before the next access. Its RAM model answers with exactly one cycle of latency.

// File: rtl/lcd_hif_pkg.sv
package lcd_hif_pkg;
  localparam int HOST_DW = 8;
  localparam int HOST_HW = HOST_DW / 2;
  localparam int ADDR_W  = 7;

  typedef enum logic {
    TGT_DISP = 1'b0,
    TGT_CHAR = 1'b1
  } ram_tgt_e;

  typedef struct packed {
    logic               rs;
    logic               rw;
    logic [HOST_DW-1:0] data;
  } host_xfer_t;
endpackage

// File: rtl/lcd_hif_sampler.sv
module lcd_hif_sampler
  import lcd_hif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_e,
  input  logic               bus_rs,
  input  logic               bus_rw,
  input  logic [HOST_DW-1:0] bus_din,
  input  logic               four_bit,
  input  logic               busy,
  input  logic               nib_clr,
  output logic               xfer_valid,
  output host_xfer_t         xfer,
  output logic               nib_lo
);
  logic               e_q;
  logic               fall;
  logic               is_status;
  logic               take;
  logic [HOST_HW-1:0] hi_q;

  assign fall      = e_q & ~bus_e;
  assign is_status = ~bus_rs & bus_rw;
  assign take      = fall & (~busy | is_status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_q        <= 1'b0;
      nib_lo     <= 1'b0;
      hi_q       <= '0;
      xfer_valid <= 1'b0;
      xfer       <= '0;
    end else begin
      e_q        <= bus_e;
      xfer_valid <= 1'b0;
      if (nib_clr) nib_lo <= 1'b0;
      if (take) begin
        if (!four_bit) begin
          xfer_valid <= 1'b1;
          xfer       <= '{rs: bus_rs, rw: bus_rw, data: bus_din};
        end else if (!nib_lo) begin
          hi_q   <= bus_din[HOST_DW-1:HOST_HW];
          nib_lo <= 1'b1;
        end else begin
          nib_lo     <= 1'b0;
          xfer_valid <= 1'b1;
          xfer       <= '{rs: bus_rs, rw: bus_rw,
                          data: {hi_q, bus_din[HOST_DW-1:HOST_HW]}};
        end
      end
    end
  end

  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && busy && !is_status) |=> !xfer_valid);  // R9
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> !xfer_valid);  // R1
endmodule

// File: rtl/lcd_hif_addr.sv
module lcd_hif_addr
  import lcd_hif_pkg::*;
#(
  parameter int DISP_DEPTH = 80,
  parameter int CHAR_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_char,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              inc,
  output logic [ADDR_W-1:0] ac,
  output ram_tgt_e          tgt
);
  localparam logic [ADDR_W-1:0] DISP_LAST = ADDR_W'(DISP_DEPTH - 1);
  localparam logic [ADDR_W-1:0] CHAR_LAST = ADDR_W'(CHAR_DEPTH - 1);

  logic [ADDR_W-1:0] last_cur;
  logic [ADDR_W-1:0] last_new;

  assign last_cur = (tgt == TGT_CHAR) ? CHAR_LAST : DISP_LAST;
  assign last_new = load_char ? CHAR_LAST : DISP_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac  <= '0;
      tgt <= TGT_DISP;
    end else if (load) begin
      tgt <= load_char ? TGT_CHAR : TGT_DISP;
      ac  <= (load_val > last_new) ? '0 : load_val;
    end else if (step) begin
      if (inc) ac <= (ac == last_cur) ? '0 : ac + 1'b1;
      else     ac <= (ac == '0) ? last_cur : ac - 1'b1;
    end
  end

  AST_AC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ac <= last_cur);  // R6
  AST_AC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ac != $past(ac)));  // R5
endmodule

// File: rtl/lcd_hif_busy.sv
module lcd_hif_busy #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);  // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (BUSY_CYCLES > 1 && $rose(busy)) |=> busy);  // R8
endmodule

// File: rtl/lcd_host_regif.sv
module lcd_host_regif
  import lcd_hif_pkg::*;
#(
  parameter int DISP_DEPTH  = 80,
  parameter int CHAR_DEPTH  = 64,
  parameter int BUSY_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_e,
  input  logic         bus_rs,
  input  logic         bus_rw,
  input  logic [7:0]   bus_din,
  output logic [7:0]   bus_dout,
  output logic         busy,
  output logic         ram_en,
  output logic         ram_we,
  output logic         ram_char,
  output logic [6:0]   ram_addr,
  output logic [7:0]   ram_wdata,
  input  logic [7:0]   ram_rdata
);
  host_xfer_t        xfer;
  logic              xfer_valid;
  logic              nib_lo;
  logic              four_bit_q;
  logic              inc_q;
  logic [HOST_DW-1:0] dr_q;
  logic              rd_req_q, rd_wait_q, rd_cap_q;
  logic [ADDR_W-1:0] ac;
  ram_tgt_e          tgt;

  logic is_instr, is_wdata, is_rdata;
  logic op_set_disp, op_set_char, op_mode, op_entry;
  logic ac_load, ac_load_char, ac_step, busy_start, nib_clr;
  logic [ADDR_W-1:0] ac_load_val;
  logic [HOST_DW-1:0] shown;

  lcd_hif_sampler u_sampler (
    .clk, .rst_n, .bus_e, .bus_rs, .bus_rw, .bus_din,
    .four_bit(four_bit_q), .busy, .nib_clr,
    .xfer_valid, .xfer, .nib_lo
  );

  assign is_instr = xfer_valid & ~xfer.rs & ~xfer.rw;
  assign is_wdata = xfer_valid &  xfer.rs & ~xfer.rw;
  assign is_rdata = xfer_valid &  xfer.rs &  xfer.rw;

  assign op_set_disp = xfer.data[7];
  assign op_set_char = xfer.data[7:6] == 2'b01;
  assign op_mode     = xfer.data[7:5] == 3'b001;
  assign op_entry    = xfer.data[7:2] == 6'b000001;

  assign ac_load      = is_instr & (op_set_disp | op_set_char);
  assign ac_load_char = ~op_set_disp;
  assign ac_load_val  = op_set_disp ? xfer.data[6:0] : {1'b0, xfer.data[5:0]};
  assign ac_step      = is_wdata | is_rdata;
  assign busy_start   = is_instr | is_wdata;
  assign nib_clr      = is_instr & op_mode;

  lcd_hif_addr #(
    .DISP_DEPTH(DISP_DEPTH),
    .CHAR_DEPTH(CHAR_DEPTH)
  ) u_addr (
    .clk, .rst_n,
    .load(ac_load), .load_char(ac_load_char), .load_val(ac_load_val),
    .step(ac_step), .inc(inc_q), .ac, .tgt
  );

  lcd_hif_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk, .rst_n, .start(busy_start), .busy
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      four_bit_q <= 1'b0;
      inc_q      <= 1'b1;
      dr_q       <= '0;
      rd_req_q   <= 1'b0;
      rd_wait_q  <= 1'b0;
      rd_cap_q   <= 1'b0;
      ram_en     <= 1'b0;
      ram_we     <= 1'b0;
      ram_char   <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
    end else begin
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      rd_req_q  <= ac_load | is_rdata;
      rd_wait_q <= rd_req_q;
      rd_cap_q  <= rd_wait_q;
      if (is_instr && op_mode)  four_bit_q <= ~xfer.data[4];
      if (is_instr && op_entry) inc_q      <= xfer.data[1];
      if (is_wdata) begin
        ram_en    <= 1'b1;
        ram_we    <= 1'b1;
        ram_char  <= (tgt == TGT_CHAR);
        ram_addr  <= ac;
        ram_wdata <= xfer.data;
        dr_q      <= xfer.data;
      end else if (rd_req_q) begin
        ram_en   <= 1'b1;
        ram_char <= (tgt == TGT_CHAR);
        ram_addr <= ac;
      end
      if (rd_cap_q) dr_q <= ram_rdata;
    end
  end

  assign shown    = bus_rs ? dr_q : {busy, ac};
  assign bus_dout = four_bit_q
                  ? {(nib_lo ? shown[HOST_HW-1:0] : shown[HOST_DW-1:HOST_HW]), {HOST_HW{1'b0}}}
                  : shown;

  AST_WE_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en);  // R3
  AST_RAM_ADDR_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (ram_char ? (int'(ram_addr) < CHAR_DEPTH)
                         : (int'(ram_addr) < DISP_DEPTH)));  // R6
  AST_NO_STEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ac_step |-> $past(!busy));  // R9
endmodule

// File: tb/test_lcd_host_regif.sv
module test_lcd_host_regif;
  localparam int BUSY = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       busy, ram_en, ram_we, ram_char;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = '0;

  logic [7:0] disp_mem [0:79];
  logic [7:0] char_mem [0:63];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcd_host_regif #(.BUSY_CYCLES(BUSY)) i_lcd_host_regif (
    .clk, .rst_n, .bus_e, .bus_rs, .bus_rw, .bus_din, .bus_dout, .busy,
    .ram_en, .ram_we, .ram_char, .ram_addr, .ram_wdata, .ram_rdata
  );

  // RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_char ? (ram_addr > 7'd63) : (ram_addr > 7'd79)) begin
        errors++;
        $display("FAIL R6 ram address out of range: actual %0h expected below limit", ram_addr);
      end else if (ram_we) begin
        if (ram_char) char_mem[ram_addr[5:0]] <= ram_wdata;
        else          disp_mem[ram_addr]      <= ram_wdata;
      end else begin
        ram_rdata <= ram_char ? char_mem[ram_addr[5:0]] : disp_mem[ram_addr];
      end
    end
  end

  function automatic logic [7:0] dpat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] cpat(int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic rs, input logic rw, input logic [7:0] d,
                        output logic [7:0] q);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_din = d; bus_e = 1'b1;
    @(negedge clk);
    q = bus_dout;
    bus_e = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr8(input logic rs, input logic [7:0] d);
    logic [7:0] q;
    strobe(rs, 1'b0, d, q);
    idle(BUSY + 4);
  endtask

  task automatic rd8(input logic rs, output logic [7:0] q);
    strobe(rs, 1'b1, 8'h00, q);
    idle(8);
  endtask

  task automatic wr4(input logic rs, input logic [7:0] d);
    logic [7:0] q;
    strobe(rs, 1'b0, {d[7:4], 4'h0}, q);
    idle(2);
    strobe(rs, 1'b0, {d[3:0], 4'h0}, q);
    idle(BUSY + 4);
  endtask

  task automatic rd4(input logic rs, output logic [7:0] q);
    logic [7:0] qh, ql;
    strobe(rs, 1'b1, 8'h00, qh);
    idle(2);
    strobe(rs, 1'b1, 8'h00, ql);
    chk("R10 low dout bits zero", {qh[3:0], ql[3:0]}, 8'h00);
    q = {qh[7:4], ql[7:4]};
    idle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int nb;
    int exp_ac;
    for (int i = 0; i < 80; i++) disp_mem[i] = 8'h00;
    for (int i = 0; i < 64; i++) char_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    bus_rs = 1'b0; bus_rw = 1'b1;
    #1;
    chk("R11 status after reset", bus_dout, 8'h00);
    chk("R11 busy/ram_en after reset", {6'b0, busy, ram_en}, 8'h00);
    bus_rs = 1'b1;
    #1;
    chk("R11 data register after reset", bus_dout, 8'h00);

    // R8 exact busy window after an instruction
    strobe(1'b0, 1'b0, 8'h80, q);
    nb = 0;
    for (int i = 0; i < BUSY + 10; i++) begin
      @(negedge clk);
      if (busy) nb++;
    end
    chk("R8 busy cycle count", 8'(nb), 8'(BUSY));

    // R2 instruction register not readable
    wr8(1'b0, 8'h06);
    rd8(1'b0, q);
    chk("R2 status not instruction", q, 8'h00);

    // R1 R3 R5 R6 display sweep, increment
    exp_ac = 0;
    for (int a = 0; a < 80; a++) begin
      wr8(1'b1, dpat(a));
      exp_ac = (a + 1) % 80;
      rd8(1'b0, q);
      chk(a == 79 ? "R6 display wrap up" : "R5 step up after write", q, 8'(exp_ac));
    end
    for (int a = 0; a < 80; a++) chk("R3 display stored", disp_mem[a], dpat(a));

    // R4 R7 read-back sweep with prefetch
    wr8(1'b0, 8'h80);
    for (int a = 0; a < 80; a++) begin
      rd8(1'b1, q);
      chk("R4 data read prefetch", q, dpat(a));
    end
    rd8(1'b0, q);
    chk("R6 display wrap after reads", q, 8'h00);

    // R7 out-of-range display address
    wr8(1'b0, 8'hD0);
    rd8(1'b0, q);
    chk("R7 out-of-range address", q, 8'h00);
    wr8(1'b0, 8'hA3);
    rd8(1'b1, q);
    chk("R7 set-address prefetch", q, dpat(35));

    // R1 decrement, character RAM, R6 wrap down
    wr8(1'b0, 8'h04);
    wr8(1'b0, 8'h40);
    exp_ac = 0;
    for (int k = 0; k < 64; k++) begin
      wr8(1'b1, cpat(exp_ac));
      exp_ac = (exp_ac + 63) % 64;
      rd8(1'b0, q);
      chk(k == 0 ? "R6 char wrap down" : "R5 step down after write", q, 8'(exp_ac));
    end
    for (int a = 0; a < 64; a++) chk("R3 char stored", char_mem[a], cpat(a));
    wr8(1'b0, 8'h7F);
    for (int a = 63; a >= 0; a--) begin
      rd8(1'b1, q);
      chk("R4 char read decrement", q, cpat(a));
    end

    // R8 R9 accesses during busy
    wr8(1'b0, 8'h06);
    wr8(1'b0, 8'h85);
    strobe(1'b1, 1'b0, 8'h11, q);
    strobe(1'b0, 1'b1, 8'h00, q);
    chk("R8 status shows busy", q, 8'h86);
    strobe(1'b1, 1'b0, 8'h22, q);
    strobe(1'b1, 1'b1, 8'h00, q);
    idle(BUSY + 4);
    rd8(1'b0, q);
    chk("R9 counter unchanged by ignored accesses", q, 8'h06);
    chk("R9 ignored write left RAM", disp_mem[6], dpat(6));
    wr8(1'b0, 8'h85);
    rd8(1'b1, q);
    chk("R3 first write kept", q, 8'h11);
    rd8(1'b1, q);
    chk("R9 second write ignored", q, dpat(6));

    // R10 4-bit bus
    wr8(1'b0, 8'h20);
    wr4(1'b0, 8'h8A);
    rd4(1'b0, q);
    chk("R10 4-bit status", q, 8'h0A);
    wr4(1'b1, 8'hC3);
    rd4(1'b0, q);
    chk("R10 4-bit status after write", q, 8'h0B);
    chk("R10 4-bit write stored", disp_mem[10], 8'hC3);
    wr4(1'b0, 8'h8A);
    rd4(1'b1, q);
    chk("R10 4-bit data read", q, 8'hC3);
    wr4(1'b0, 8'h30);
    rd8(1'b0, q);
    chk("R1 back to 8-bit", q, 8'h0B);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule